// File: doc/BRIEF.md
# Two-Wire Bus Recovery and Acknowledge-Poll Sequencer

This block is the controller side of a two-wire serial bus. It drives open-drain enables for the clock and data lines from a system clock. One phase of the bus clock lasts a number of system clocks set at run time. On command it performs one of two jobs. The first is a recovery pattern that frees a slave left halfway through a byte: a Start condition, nine clocks with data released, a second Start and then a Stop. The second is a completion poll for a memory that is busy with its internal write. The poll addresses the memory for a write with no payload. A not-acknowledge means the memory is still busy, so the block sends a Stop and tries again. An acknowledge means the memory is ready.

After an acknowledge the block sends a Stop and reports done. It can instead be told to keep the bus, leaving the clock held low for a later transfer. A programmable attempt limit bounds the loop; when the limit is used up the block sends a Stop and reports a timeout. The number of attempts made stays visible on an output, so a write time can be measured in poll attempts.

Top module: `bus_rescue_poller`

## Requirements
- R1: After synchronous reset both line enables are low (lines released), `busy`, `done` and `timeout` are low and `tries` is 0.
- R2: A recovery command produces one Start, then nine clock pulses with data released, then a second Start, then a Stop. After it the bus is idle (both lines high) and `done` pulses for one cycle.
- R3: A poll attempt is a Start followed by eight data bits sent most significant bit first: the 7-bit `dev_addr`, then a 0 as the last bit (write direction). Data is sampled during the ninth clock; data low means acknowledge.
- R4: On a not-acknowledge below the attempt limit, the block sends a Stop and then starts a new attempt. `tries` is cleared when a command is accepted and rises by one at each attempt.
- R5: On an acknowledge with `hold_bus` low, the block sends a Stop, then pulses `done` for one cycle. `tries` then equals the number of attempts made.
- R6: On an acknowledge with `hold_bus` high, no Stop is sent. `done` pulses and the clock line stays driven low with data released until the next command.
- R7: When the attempt that brings `tries` to the limit gets a not-acknowledge, the block sends a Stop and pulses `timeout`, never `done`. The limit is `max_tries`; a value of 0 is treated as 1.
- R8: The data line changes while the clock line is high only to form a Start or a Stop. No other Start or Stop appears on the bus.
- R9: Every data, acknowledge and dummy clock pulse stays high for exactly `cfg_half` system clocks; a value of 0 is treated as 1. The value is taken while the block is idle.
- R10: Commands that arrive while `busy` is high are ignored. If both commands arrive in the same cycle, recovery is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | HALF_W | System clocks per bus clock phase (0 acts as 1) |
| max_tries | input | TRY_W | Attempt limit for polling (0 acts as 1) |
| dev_addr | input | ADDR_W | 7-bit target address used by the poll |
| hold_bus | input | 1 | Keep the bus after an acknowledge instead of sending Stop |
| cmd_recover | input | 1 | Start the recovery pattern |
| cmd_poll | input | 1 | Start the completion poll |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | Pull the clock line low when 1 |
| sda_oe | output | 1 | Pull the data line low when 1 |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: recovery finished or target answered |
| timeout | output | 1 | One-cycle pulse: attempt limit used up |
| tries | output | TRY_W | Attempts made in the current or last poll |

## Verification
Several rules are checked on every cycle. Data moves under a high clock only inside Start or Stop symbols. `done` and `timeout` are exclusive single-cycle pulses. The attempt count only steps by one or clears, and never passes the latched limit. An idle block leaves both lines released, and a held bus keeps only the clock low. Other behaviour can only be shown by the bench's scenarios. These include the order of symbols in the recovery pattern, the address bits as a slave model receives them, and the number of attempts for a given busy length and limit. The bench also measures the clock high width in system clocks and checks that commands during a run are ignored.

// File: rtl/bus_rescue_pkg.sv
package bus_rescue_pkg;

    // Bus symbols the line engine can emit
    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_BIT   = 2'd1,
        SYM_STOP  = 2'd2
    } sym_kind_t;

    // Pull-low requests for the two lines
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drv_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_REC,
        SQ_P_START,
        SQ_P_ADDR,
        SQ_P_ACK,
        SQ_RETRY_STOP,
        SQ_END_STOP
    } seq_state_t;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_OK,
        OUT_TIMEOUT
    } outcome_t;

    // Recovery pattern: Start, dummy clocks, Start, Stop
    localparam int REC_DUMMY = 9;
    localparam int REC_LEN   = REC_DUMMY + 3;

    // Line levels per symbol phase. Every symbol leaves SCL low,
    // except Stop, which leaves the bus idle.
    function automatic line_drv_t sym_lines(sym_kind_t k, logic [1:0] ph, logic b);
        line_drv_t d;
        d = '{scl_low: 1'b0, sda_low: 1'b0};
        case (k)
            SYM_START: begin
                d.scl_low = (ph == 2'd0) || (ph == 2'd3);
                d.sda_low = (ph >= 2'd2);
            end
            SYM_BIT: begin
                d.scl_low = (ph != 2'd1);
                d.sda_low = !b;
            end
            default: begin
                d.scl_low = (ph == 2'd0);
                d.sda_low = (ph != 2'd2);
            end
        endcase
        return d;
    endfunction

    function automatic logic [1:0] sym_last_phase(sym_kind_t k);
        return (k == SYM_START) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] limit,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;

    assign tick = run && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/line_symbol_engine.sv
module line_symbol_engine
    import bus_rescue_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  sym_kind_t         kind_in,
    input  logic              bit_in,
    input  logic [HALF_W-1:0] limit,
    input  logic              sda_in,
    output logic              ready,
    output logic              sym_done,
    output logic              sampled,
    output sym_kind_t         cur_kind,
    output logic              scl_oe,
    output logic              sda_oe
);
    logic       active;
    logic [1:0] ph;
    logic       bit_q;
    logic       tick;
    line_drv_t  nxt;

    scl_phase_timer #(.HALF_W(HALF_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (active),
        .limit (limit),
        .tick  (tick)
    );

    assign ready = !active;
    assign nxt   = sym_lines(cur_kind, ph + 2'd1, bit_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            ph       <= 2'd0;
            bit_q    <= 1'b1;
            cur_kind <= SYM_STOP;
            sym_done <= 1'b0;
            sampled  <= 1'b1;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            sym_done <= 1'b0;
            if (!active && go) begin
                active            <= 1'b1;
                ph                <= 2'd0;
                bit_q             <= bit_in;
                cur_kind          <= kind_in;
                {scl_oe, sda_oe}  <= sym_lines(kind_in, 2'd0, bit_in);
            end else if (active && tick) begin
                // sample data at the end of the clock-high phase
                if (cur_kind == SYM_BIT && ph == 2'd1) begin
                    sampled <= sda_in;
                end
                if (ph == sym_last_phase(cur_kind)) begin
                    active   <= 1'b0;
                    sym_done <= 1'b1;
                end else begin
                    ph               <= ph + 2'd1;
                    {scl_oe, sda_oe} <= nxt;
                end
            end
        end
    end
endmodule

// File: rtl/rescue_sequencer.sv
module rescue_sequencer
    import bus_rescue_pkg::*;
#(
    parameter int TRY_W  = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_recover,
    input  logic              cmd_poll,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [TRY_W-1:0]  max_tries,
    input  logic              hold_bus,
    input  logic              eng_ready,
    input  logic              sym_done,
    input  logic              sampled,
    output logic              go,
    output sym_kind_t         kind,
    output logic              bit_val,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              held,
    output logic [TRY_W-1:0]  tries,
    output logic [TRY_W-1:0]  try_limit
);
    localparam int BYTE_BITS = ADDR_W + 1;
    localparam int SEQ_MAX   = (REC_LEN > BYTE_BITS) ? REC_LEN : BYTE_BITS;
    localparam int IDX_W     = $clog2(SEQ_MAX);

    seq_state_t           st;
    logic [IDX_W-1:0]     idx;
    logic                 issued;
    logic [BYTE_BITS-1:0] hdr_init;
    logic [BYTE_BITS-1:0] hdr;
    logic                 hold_q;
    outcome_t             outc;

    assign hdr_init = {dev_addr, 1'b0};
    assign busy     = (st != SQ_IDLE);
    assign go       = busy && !issued && eng_ready;

    always_comb begin
        kind    = SYM_STOP;
        bit_val = 1'b1;
        case (st)
            SQ_REC: begin
                if (idx == '0 || idx == IDX_W'(REC_DUMMY + 1)) begin
                    kind = SYM_START;
                end else if (idx == IDX_W'(REC_LEN - 1)) begin
                    kind = SYM_STOP;
                end else begin
                    kind = SYM_BIT;
                end
            end
            SQ_P_START: kind = SYM_START;
            SQ_P_ADDR: begin
                kind    = SYM_BIT;
                bit_val = hdr[BYTE_BITS-1];
            end
            SQ_P_ACK:   kind = SYM_BIT;
            default:    kind = SYM_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            idx       <= '0;
            issued    <= 1'b0;
            hdr       <= '1;
            hold_q    <= 1'b0;
            outc      <= OUT_NONE;
            done      <= 1'b0;
            timeout   <= 1'b0;
            held      <= 1'b0;
            tries     <= '0;
            try_limit <= TRY_W'(1);
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            if (go) begin
                issued <= 1'b1;
            end
            if (go && st == SQ_P_START) begin
                tries <= tries + 1'b1;
            end
            if (st == SQ_IDLE) begin
                if (cmd_recover) begin
                    st    <= SQ_REC;
                    idx   <= '0;
                    tries <= '0;
                    held  <= 1'b0;
                end else if (cmd_poll) begin
                    st        <= SQ_P_START;
                    tries     <= '0;
                    held      <= 1'b0;
                    hold_q    <= hold_bus;
                    try_limit <= (max_tries == '0) ? TRY_W'(1) : max_tries;
                end
            end else if (sym_done) begin
                issued <= 1'b0;
                case (st)
                    SQ_REC: begin
                        if (idx == IDX_W'(REC_LEN - 1)) begin
                            st   <= SQ_IDLE;
                            done <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    SQ_P_START: begin
                        st  <= SQ_P_ADDR;
                        idx <= '0;
                        hdr <= hdr_init;
                    end
                    SQ_P_ADDR: begin
                        hdr <= {hdr[BYTE_BITS-2:0], 1'b1};
                        if (idx == IDX_W'(BYTE_BITS - 1)) begin
                            st <= SQ_P_ACK;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    SQ_P_ACK: begin
                        if (!sampled) begin
                            if (hold_q) begin
                                st   <= SQ_IDLE;
                                done <= 1'b1;
                                held <= 1'b1;
                            end else begin
                                st   <= SQ_END_STOP;
                                outc <= OUT_OK;
                            end
                        end else if (tries >= try_limit) begin
                            st   <= SQ_END_STOP;
                            outc <= OUT_TIMEOUT;
                        end else begin
                            st <= SQ_RETRY_STOP;
                        end
                    end
                    SQ_RETRY_STOP: st <= SQ_P_START;
                    SQ_END_STOP: begin
                        st      <= SQ_IDLE;
                        done    <= (outc == OUT_OK);
                        timeout <= (outc == OUT_TIMEOUT);
                    end
                    default: st <= SQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/bus_rescue_poller.sv
module bus_rescue_poller
    import bus_rescue_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int TRY_W  = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [TRY_W-1:0]  max_tries,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              hold_bus,
    input  logic              cmd_recover,
    input  logic              cmd_poll,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [TRY_W-1:0]  tries
);
    logic [HALF_W-1:0] limit_q;
    logic              go;
    sym_kind_t         req_kind;
    logic              req_bit;
    logic              eng_ready;
    logic              sym_done;
    logic              sampled;
    sym_kind_t         eng_kind;
    logic              held;
    logic [TRY_W-1:0]  try_limit;

    // phase length is frozen while a command runs
    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= HALF_W'(1);
        end else if (!busy) begin
            limit_q <= (cfg_half == '0) ? HALF_W'(1) : cfg_half;
        end
    end

    rescue_sequencer #(.TRY_W(TRY_W), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_recover (cmd_recover),
        .cmd_poll    (cmd_poll),
        .dev_addr    (dev_addr),
        .max_tries   (max_tries),
        .hold_bus    (hold_bus),
        .eng_ready   (eng_ready),
        .sym_done    (sym_done),
        .sampled     (sampled),
        .go          (go),
        .kind        (req_kind),
        .bit_val     (req_bit),
        .busy        (busy),
        .done        (done),
        .timeout     (timeout),
        .held        (held),
        .tries       (tries),
        .try_limit   (try_limit)
    );

    line_symbol_engine #(.HALF_W(HALF_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .kind_in  (req_kind),
        .bit_in   (req_bit),
        .limit    (limit_q),
        .sda_in   (sda_in),
        .ready    (eng_ready),
        .sym_done (sym_done),
        .sampled  (sampled),
        .cur_kind (eng_kind),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );
endmodule

// File: rtl/bus_rescue_poller_chk.sv
module bus_rescue_poller_chk
    import bus_rescue_pkg::*;
#(
    parameter int TRY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             busy,
    input logic             done,
    input logic             timeout,
    input logic             held,
    input logic [TRY_W-1:0] tries,
    input logic [TRY_W-1:0] try_limit,
    input sym_kind_t        eng_kind
);
    AST_SDA_ONLY_AT_EDGES: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
            |-> (eng_kind == SYM_START || eng_kind == SYM_STOP)); // R8

    AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout); // R7

    AST_TRIES_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tries <= try_limit)); // R7

    AST_TRIES_STEP: assert property (@(posedge clk) disable iff (rst)
        (tries != $past(tries)) |-> ((tries == $past(tries) + 1'b1) || (tries == '0))); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!busy && !held) |-> (!scl_oe && !sda_oe)); // R2

    AST_HOLD_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        held |-> (scl_oe && !sda_oe)); // R6
endmodule

bind bus_rescue_poller bus_rescue_poller_chk #(.TRY_W(TRY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .held      (held),
    .tries     (tries),
    .try_limit (try_limit),
    .eng_kind  (eng_kind)
);

// File: tb/bus_rescue_poller_test.sv
module bus_rescue_poller_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_half = 16'd2;
    logic [7:0]  max_tries = 8'd1;
    logic [6:0]  dev_addr = 7'h50;
    logic        hold_bus = 1'b0;
    logic        cmd_recover = 1'b0;
    logic        cmd_poll = 1'b0;
    logic        scl_oe, sda_oe, busy, done, timeout;
    logic [7:0]  tries;
    logic        slv_pull = 1'b0;
    wire         scl_w = ~scl_oe;
    wire         sda_w = ~(sda_oe | slv_pull);

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_rescue_poller uut (
        .clk(clk), .rst(rst), .cfg_half(cfg_half), .max_tries(max_tries),
        .dev_addr(dev_addr), .hold_bus(hold_bus), .cmd_recover(cmd_recover),
        .cmd_poll(cmd_poll), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .timeout(timeout), .tries(tries)
    );

    // ---- slave model: watches the lines, acks its address once not busy ----
    int         bitcnt = 10, starts = 0, stops = 0, rises_since = 0;
    int         gap_at_start = 0, gap_at_stop = 0, attempts = 0, busy_left = 0;
    logic [7:0] shreg = 8'hFF, last_byte = 8'h00;
    logic [6:0] slv_addr = 7'h50;
    logic       p_scl = 1'b1, p_sda = 1'b1;

    always @(scl_w or sda_w) begin
        if (scl_w && p_scl && p_sda && !sda_w) begin
            starts++; gap_at_start = rises_since; rises_since = 0; bitcnt = 0;
        end else if (scl_w && p_scl && !p_sda && sda_w) begin
            stops++; gap_at_stop = rises_since;
        end else if (scl_w && !p_scl) begin
            rises_since++;
            if (bitcnt < 8) shreg = {shreg[6:0], sda_w};
            if (bitcnt < 9) bitcnt++;
        end else if (!scl_w && p_scl) begin
            if (bitcnt == 8) begin
                if (shreg == {slv_addr, 1'b0}) begin
                    attempts++; last_byte = shreg;
                    if (busy_left == 0) slv_pull = 1'b1;
                    else busy_left--;
                end
            end else if (bitcnt == 9) begin
                slv_pull = 1'b0; bitcnt = 10;
            end
        end
        p_scl = scl_w; p_sda = sda_w;
    end

    // ---- cycle monitor, sampled away from the active edge ----
    int   done_cnt = 0, to_cnt = 0, half_pulses = 0, hi_len = 0;
    int   cur_half = 2;
    logic scl_prev = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt++;
            if (timeout) to_cnt++;
            if (scl_w) hi_len++;
            else begin
                if (scl_prev && hi_len == cur_half) half_pulses++;
                hi_len = 0;
            end
            scl_prev = scl_w;
        end
    end

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        starts = 0; stops = 0; attempts = 0; done_cnt = 0; to_cnt = 0;
        half_pulses = 0; gap_at_start = 0; gap_at_stop = 0; last_byte = 8'h00;
    endtask

    task automatic wait_end();
        int n;
        n = 0;
        repeat (2) @(negedge clk);
        while (busy && n < WAIT_LIMIT) begin
            @(negedge clk); n++;
        end
        if (n >= WAIT_LIMIT) chk(1'b0, "watchdog", n, WAIT_LIMIT);
        repeat (3) @(negedge clk);
    endtask

    task automatic issue(input bit rec, input bit pol);
        @(negedge clk);
        cmd_recover = rec; cmd_poll = pol;
        @(negedge clk);
        cmd_recover = 1'b0; cmd_poll = 1'b0;
    endtask

    task automatic run_recovery(input int half, input string tag);
        cfg_half = 16'(half); cur_half = (half == 0) ? 1 : half;
        clear_obs();
        issue(1'b1, 1'b0);
        wait_end();
        chk(starts == 2, {tag, " R2 starts"}, starts, 2);
        chk(stops == 1, {tag, " R2 stops"}, stops, 1);
        chk(gap_at_start == 10, {tag, " R2 clocks before second start"}, gap_at_start, 10);
        chk(gap_at_stop == 1, {tag, " R2 stop right after start"}, gap_at_stop, 1);
        chk(half_pulses == 9, {tag, " R9 dummy clock width"}, half_pulses, 9);
        chk(scl_w && sda_w, {tag, " R2 bus idle"}, {scl_w, sda_w}, 3);
        chk(done_cnt == 1 && to_cnt == 0, {tag, " R2 done pulse"}, done_cnt, 1);
        chk(attempts == 0, {tag, " R8 no address seen"}, attempts, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(!busy && !done && !timeout, "R1 flags low", {busy, done, timeout}, 0);
        chk(tries == 0, "R1 tries", tries, 0);

        // recovery across phase lengths, including 0 treated as 1
        for (int h = 0; h <= 3; h++) run_recovery(h, "rec");

        // poll sweep: busy length x attempt limit x hold
        cfg_half = 16'd2; cur_half = 2;
        for (int nb = 0; nb <= 4; nb++) begin
            for (int mx = 0; mx <= 4; mx++) begin
                for (int hb = 0; hb <= 1; hb++) begin
                    int mx_eff, att, exp_stops;
                    bit acked;
                    mx_eff = (mx == 0) ? 1 : mx;
                    acked = (nb + 1) <= mx_eff;
                    att = acked ? nb + 1 : mx_eff;
                    exp_stops = (acked && hb == 1) ? att - 1 : att;
                    dev_addr = 7'h2A ^ 7'(nb * 5 + mx * 3 + hb);
                    slv_addr = dev_addr;
                    max_tries = 8'(mx); hold_bus = hb[0]; busy_left = nb;
                    clear_obs();
                    issue(1'b0, 1'b1);
                    wait_end();
                    chk(attempts == att, "R4 attempts seen by slave", attempts, att);
                    chk(tries == 8'(att), "R4 tries output", tries, att);
                    chk(last_byte == {dev_addr, 1'b0}, "R3 header byte", last_byte, {dev_addr, 1'b0});
                    chk(starts == att, "R8 start count", starts, att);
                    chk(stops == exp_stops, "R4 stop count", stops, exp_stops);
                    chk(half_pulses == 9 * att, "R9 clock width", half_pulses, 9 * att);
                    if (exp_stops > 0)
                        chk(gap_at_stop == 10, "R3 nine clocks then stop", gap_at_stop, 10);
                    if (acked) begin
                        chk(done_cnt == 1 && to_cnt == 0, "R5 done pulse", done_cnt, 1);
                        if (hb == 1)
                            chk(!scl_w && sda_w, "R6 clock held low", {scl_w, sda_w}, 1);
                        else
                            chk(scl_w && sda_w, "R5 bus idle", {scl_w, sda_w}, 3);
                    end else begin
                        chk(to_cnt == 1 && done_cnt == 0, "R7 timeout pulse", to_cnt, 1);
                        chk(scl_w && sda_w, "R7 bus idle", {scl_w, sda_w}, 3);
                    end
                end
            end
        end

        // R10: poll command during a recovery is ignored
        cfg_half = 16'd2; cur_half = 2; hold_bus = 1'b0; busy_left = 0;
        clear_obs();
        issue(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        cmd_poll = 1'b1; @(negedge clk); cmd_poll = 1'b0;
        wait_end();
        chk(attempts == 0, "R10 ignored poll attempts", attempts, 0);
        chk(tries == 0, "R10 ignored poll tries", tries, 0);
        chk(done_cnt == 1, "R10 single done", done_cnt, 1);
        chk(!busy, "R10 back to idle", busy, 0);

        // R10: both commands at once, recovery wins
        clear_obs();
        issue(1'b1, 1'b1);
        wait_end();
        chk(attempts == 0 && starts == 2, "R10 recovery priority", starts, 2);
        chk(half_pulses == 9, "R10 recovery clocks", half_pulses, 9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule